// File: doc/BRIEF.md
# Page-Mode Nibble DRAM Fetch Sequencer

This block fetches display bytes from a DRAM that is only four bits wide. It runs on a 16 MHz clock. It splits every 2 MHz slot into eight phases, numbered 0 to 7. In a slot that performs a fetch, it opens one DRAM row with a single row strobe. It then issues two column strobes in page mode and captures one half-byte after each. The two half-bytes are joined into one byte, which is presented with a one-cycle valid pulse.

A built-in timebase counts phases, slots within a scanline and scanlines within a frame. It enables fetches only in the active part of the picture: the first `ACT_SLOTS` slots of each of the first `ACT_LINES` lines. The client holds a request and a byte address during one slot. The sequencer samples both at the slot boundary and runs the access in the following slot, if that slot lies inside the active window.

The byte address is `2*DRAM_AW-1` bits wide. Its upper `DRAM_AW` bits form the row. Its lower `DRAM_AW-1` bits form the column. A nibble-select bit is added below the column bits as the column's least significant bit.

Top module: `nibble_fetch_seq`

## Requirements
- R1: A synchronous active-high reset holds both strobes high and the valid output low in the cycle after it is sampled. It restarts the timebase at phase 0, slot 0, line 0, and the first slot after reset performs no access.
- R2: `fetch_req` and `byte_addr` are sampled at the clock edge that ends phase 7 of a slot. Only that sample decides whether the next slot fetches, and which byte it fetches.
- R3: In a fetching slot, `dram_ras_n` is low in phases 1 to 5 and high in phases 0, 6 and 7.
- R4: In a fetching slot, `dram_cas_n` is low only in phases 3 and 5. It is therefore never low while `dram_ras_n` is high.
- R5: In a fetching slot, `dram_addr` carries the row (byte address bits [2*DRAM_AW-2 : DRAM_AW-1]) in phases 0 and 1. It carries the column with least significant bit 0 in phases 2 and 3, and the column with least significant bit 1 in phases 4 and 5. In each case the column is byte address bits [DRAM_AW-2:0] shifted up by one. Each address is therefore stable for one phase before the strobe that latches it falls.
- R6: `dram_din` is sampled at the edge ending phase 3 (low nibble) and at the edge ending phase 5 (high nibble). `fetch_byte` then shows the joined byte while `fetch_valid` is high, for exactly one cycle, in phase 6.
- R7: A slot outside the active window asserts no strobe and no valid pulse, even when it was requested. The active window is slot < ACT_SLOTS on line < ACT_LINES.
- R8: A scanline lasts SLOTS slots of 8 phases each and a frame lasts LINES lines. After the last slot of the last line, the timebase wraps to slot 0 of line 0, which fetches again when requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request for the next slot, held during the current slot |
| byte_addr | input | 2*DRAM_AW-1 | Byte address for the requested fetch |
| dram_din | input | 4 | Data nibble from the DRAM |
| dram_addr | output | DRAM_AW | Multiplexed row/column address to the DRAM |
| dram_ras_n | output | 1 | Active-low row strobe |
| dram_cas_n | output | 1 | Active-low column strobe |
| fetch_byte | output | 8 | Assembled byte |
| fetch_valid | output | 1 | One-cycle pulse marking a new assembled byte |

## Verification
The bench goes after nibble order and sampling phase. The DRAM model drives a junk value whenever the column strobe is high, so a design that samples one phase early or late, or swaps the nibbles, returns a wrong byte. It also probes the edges of the active window and the frame wrap. A design with an off-by-one slot or line limit would raise strobes in the first blank slot, or miss the first fetch of a new frame. Requests are switched on and off at random slot boundaries, so a design that samples the request in the wrong cycle fetches in slots it should skip. A reset arriving in the middle of an open row must close both strobes at once. A design that lets the access run on would keep the row strobe low.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
    typedef logic [2:0] phase_t;

    localparam phase_t PH_RAS_ON  = 3'd1;
    localparam phase_t PH_COL_A   = 3'd2;
    localparam phase_t PH_CAS_A   = 3'd3;
    localparam phase_t PH_COL_B   = 3'd4;
    localparam phase_t PH_CAS_B   = 3'd5;
    localparam phase_t PH_RAS_OFF = 3'd6;
    localparam phase_t PH_LAST    = 3'd7;

    typedef enum logic [1:0] {ASEL_ROW, ASEL_COL_A, ASEL_COL_B} asel_e;

    // Which address the DRAM pins carry in a given phase
    function automatic asel_e asel_for(phase_t p);
        if (p < PH_COL_A)      return ASEL_ROW;
        else if (p < PH_COL_B) return ASEL_COL_A;
        else                   return ASEL_COL_B;
    endfunction
endpackage

// File: rtl/nfs_timebase.sv
module nfs_timebase
    import nfs_pkg::*;
#(
    parameter int SLOTS     = 128,
    parameter int ACT_SLOTS = 80,
    parameter int LINES     = 312,
    parameter int ACT_LINES = 256
) (
    input  logic   clk,
    input  logic   rst,
    output phase_t phase,
    output logic   slot_end,
    output logic   next_active
);
    localparam int SW = $clog2(SLOTS);
    localparam int LW = $clog2(LINES);

    typedef struct packed {
        phase_t        phase;
        logic [SW-1:0] slot;
        logic [LW-1:0] line;
    } tb_state_t;

    tb_state_t     state_q, state_d;
    logic [SW-1:0] slot_nx;
    logic [LW-1:0] line_nx;

    always_comb begin
        slot_end = (state_q.phase == PH_LAST);
        slot_nx  = (state_q.slot == SW'(SLOTS - 1)) ? '0 : state_q.slot + 1'b1;
        if (state_q.slot == SW'(SLOTS - 1))
            line_nx = (state_q.line == LW'(LINES - 1)) ? '0 : state_q.line + 1'b1;
        else
            line_nx = state_q.line;
        // Window of the slot that begins after this one
        next_active = ({1'b0, slot_nx} < (SW + 1)'(ACT_SLOTS)) &&
                      ({1'b0, line_nx} < (LW + 1)'(ACT_LINES));

        state_d       = state_q;
        state_d.phase = state_q.phase + 3'd1;
        if (slot_end) begin
            state_d.slot = slot_nx;
            state_d.line = line_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign phase = state_q.phase;
endmodule

// File: rtl/nfs_strobe.sv
module nfs_strobe
    import nfs_pkg::*;
#(
    parameter int AW   = 8,
    parameter int BA_W = 2 * AW - 1
) (
    input  logic            clk,
    input  logic            rst,
    input  phase_t          phase,
    input  logic            slot_end,
    input  logic            next_active,
    input  logic            req,
    input  logic [BA_W-1:0] baddr,
    output logic            ras_n,
    output logic            cas_n,
    output logic [AW-1:0]   addr,
    output logic            go
);
    typedef struct packed {
        logic            go;
        logic [BA_W-1:0] ba;
        logic            ras_n;
        logic            cas_n;
        logic [AW-1:0]   addr;
    } st_state_t;

    st_state_t state_q, state_d;
    phase_t    pn;

    always_comb begin
        pn      = phase + 3'd1;
        state_d = state_q;
        if (slot_end) begin
            state_d.go = req && next_active;
            state_d.ba = baddr;
        end
        // Outputs registered one phase ahead so the pins change on clean edges
        state_d.ras_n = !(state_d.go && (pn >= PH_RAS_ON) && (pn < PH_RAS_OFF));
        state_d.cas_n = !(state_d.go && ((pn == PH_CAS_A) || (pn == PH_CAS_B)));
        case (asel_for(pn))
            ASEL_COL_A: state_d.addr = {state_d.ba[AW-2:0], 1'b0};
            ASEL_COL_B: state_d.addr = {state_d.ba[AW-2:0], 1'b1};
            default:    state_d.addr = state_d.ba[BA_W-1 -: AW];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= '0;
            state_q.ras_n <= 1'b1;
            state_q.cas_n <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign ras_n = state_q.ras_n;
    assign cas_n = state_q.cas_n;
    assign addr  = state_q.addr;
    assign go    = state_q.go;
endmodule

// File: rtl/nfs_assemble.sv
module nfs_assemble
    import nfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  phase_t     phase,
    input  logic       go,
    input  logic [3:0] din,
    output logic [7:0] byte_o,
    output logic       valid
);
    typedef struct packed {
        logic [3:0] lo;
        logic [7:0] data;
        logic       valid;
    } as_state_t;

    as_state_t state_q, state_d;

    always_comb begin
        state_d       = state_q;
        state_d.valid = 1'b0;
        if (go && (phase == PH_CAS_A)) state_d.lo = din;
        if (go && (phase == PH_CAS_B)) begin
            state_d.data  = {din, state_q.lo};
            state_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign byte_o = state_q.data;
    assign valid  = state_q.valid;
endmodule

// File: rtl/nibble_fetch_seq.sv
module nibble_fetch_seq
    import nfs_pkg::*;
#(
    parameter int  DRAM_AW   = 8,
    parameter int  SLOTS     = 128,
    parameter int  ACT_SLOTS = 80,
    parameter int  LINES     = 312,
    parameter int  ACT_LINES = 256,
    localparam int BA_W      = 2 * DRAM_AW - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch_req,
    input  logic [BA_W-1:0]    byte_addr,
    input  logic [3:0]         dram_din,
    output logic [DRAM_AW-1:0] dram_addr,
    output logic               dram_ras_n,
    output logic               dram_cas_n,
    output logic [7:0]         fetch_byte,
    output logic               fetch_valid
);
    phase_t phase_w;
    logic   slot_end_w;
    logic   next_active_w;
    logic   go_w;

    nfs_timebase #(
        .SLOTS(SLOTS), .ACT_SLOTS(ACT_SLOTS), .LINES(LINES), .ACT_LINES(ACT_LINES)
    ) u_timebase (
        .clk(clk), .rst(rst), .phase(phase_w),
        .slot_end(slot_end_w), .next_active(next_active_w)
    );

    nfs_strobe #(.AW(DRAM_AW), .BA_W(BA_W)) u_strobe (
        .clk(clk), .rst(rst), .phase(phase_w), .slot_end(slot_end_w),
        .next_active(next_active_w), .req(fetch_req), .baddr(byte_addr),
        .ras_n(dram_ras_n), .cas_n(dram_cas_n), .addr(dram_addr), .go(go_w)
    );

    nfs_assemble u_assemble (
        .clk(clk), .rst(rst), .phase(phase_w), .go(go_w), .din(dram_din),
        .byte_o(fetch_byte), .valid(fetch_valid)
    );
endmodule

// File: rtl/nfs_chk.sv
module nfs_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    phase,
    input logic          ras_n,
    input logic          cas_n,
    input logic [AW-1:0] addr,
    input logic          valid
);
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (ras_n && cas_n && !valid)); // R1
    AST_PRECHARGE: assert property (@(posedge clk) disable iff (rst) (phase == 3'd7 || phase == 3'd0) |-> ras_n); // R3
    AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (rst) !cas_n |-> !ras_n); // R4
    AST_CAS_PHASE: assert property (@(posedge clk) disable iff (rst) !cas_n |-> (phase == 3'd3 || phase == 3'd5)); // R4
    AST_ROW_SETUP: assert property (@(posedge clk) disable iff (rst) $fell(ras_n) |-> $stable(addr)); // R5
    AST_COL_SETUP: assert property (@(posedge clk) disable iff (rst) $fell(cas_n) |-> $stable(addr)); // R5
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst) valid |=> !valid); // R6
    AST_VALID_PHASE: assert property (@(posedge clk) disable iff (rst) valid |-> (phase == 3'd6)); // R6
endmodule

bind nibble_fetch_seq nfs_chk #(.AW(DRAM_AW)) u_chk (
    .clk(clk), .rst(rst), .phase(phase_w), .ras_n(dram_ras_n),
    .cas_n(dram_cas_n), .addr(dram_addr), .valid(fetch_valid)
);

// File: tb/sim_nibble_fetch_seq.sv
module sim_nibble_fetch_seq;
    localparam int AW    = 8;
    localparam int SL    = 16;
    localparam int ASL   = 10;
    localparam int LN    = 12;
    localparam int ALN   = 8;
    localparam int BW    = 2 * AW - 1;
    localparam int FRAME = LN * SL * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic [BW-1:0] baddr = '0;
    logic [3:0]    din;
    logic [AW-1:0] daddr;
    logic          ras_n, cas_n, fvalid;
    logic [7:0]    fbyte;
    logic [AW-1:0] row_l = '0, col_l = '0;
    int            errors = 0, checks = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    nibble_fetch_seq #(
        .DRAM_AW(AW), .SLOTS(SL), .ACT_SLOTS(ASL), .LINES(LN), .ACT_LINES(ALN)
    ) u0 (
        .clk(clk), .rst(rst), .fetch_req(req), .byte_addr(baddr), .dram_din(din),
        .dram_addr(daddr), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
        .fetch_byte(fbyte), .fetch_valid(fvalid)
    );

    function automatic logic [3:0] nib(logic [AW-1:0] r, logic [AW-1:0] c);
        return 4'((int'(r) * 7) + (int'(c) * 3) + 1);
    endfunction

    function automatic bit win(int s, int l);
        return (s < ASL) && (l < ALN);
    endfunction

    // DRAM model: latches row and column on strobe falls, junk while CAS is high
    always @(negedge ras_n) row_l <= daddr;
    always @(negedge cas_n) col_l <= daddr;
    always_comb din = cas_n ? 4'h5 : nib(row_l, col_l);

    task automatic check(bit ok, string rq, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic run(int n, bit second);
        bit            req_last = 1'b0;
        logic [BW-1:0] a_last = '0;
        bit            go = 1'b0;
        logic [BW-1:0] a_cur = '0;
        for (int t = 0; t < n; t++) begin
            int p  = t % 8;
            int s  = (t / 8) % SL;
            int l  = (t / (8 * SL)) % LN;
            int fr = t / FRAME;
            bit ras_e, cas_e, val_e;
            if (p == 0) begin
                bit            nr;
                logic [BW-1:0] na;
                go    = req_last && win(s, l);
                a_cur = a_last;
                if (second || fr == 1) nr = ($urandom % 4) != 0;
                else                   nr = (fr != 2);
                case ((t / 8) % 5)
                    0:       na = '1;
                    1:       na = '0;
                    default: na = BW'($urandom);
                endcase
                req      = nr;
                baddr    = na;
                req_last = nr;
                a_last   = na;
            end
            ras_e = go && (p >= 1) && (p <= 5);
            cas_e = go && ((p == 3) || (p == 5));
            val_e = go && (p == 6);
            if (go) begin
                check(ras_n == !ras_e, "R3 ras", ras_n, !ras_e);
                check(cas_n == !cas_e, "R4 cas", cas_n, !cas_e);
            end else begin
                check(ras_n && cas_n, (req_last && p != 0) || !win(s, l) ? "R7 idle" : "R2 idle",
                      {ras_n, cas_n}, 2'b11);
            end
            if (go && p <= 5) begin
                logic [AW-1:0] ea;
                if (p < 2)      ea = a_cur[BW-1 -: AW];
                else if (p < 4) ea = {a_cur[AW-2:0], 1'b0};
                else            ea = {a_cur[AW-2:0], 1'b1};
                check(daddr == ea, "R5 addr", daddr, ea);
            end
            check(fvalid == val_e, "R6 valid", fvalid, val_e);
            if (val_e) begin
                logic [AW-1:0] r = a_cur[BW-1 -: AW];
                logic [7:0]    eb = {nib(r, {a_cur[AW-2:0], 1'b1}), nib(r, {a_cur[AW-2:0], 1'b0})};
                check(fbyte == eb, "R6 byte", fbyte, eb);
            end
            if (s == 0 && l == 0 && p == 3 && t >= FRAME && go)
                check(cas_n == 1'b0, "R8 frame wrap fetch", cas_n, 0);
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (4) @(negedge clk);
        check(ras_n && cas_n, "R1 reset strobes", {ras_n, cas_n}, 2'b11);
        check(!fvalid, "R1 reset valid", fvalid, 0);
        rst = 1'b0;
        run(3 * FRAME + 26, 1'b0);
        // Mid-access: phase 2 of slot 3, line 0, row open
        check(ras_n == 1'b0, "R3 open row before reset", ras_n, 0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(ras_n && cas_n, "R1 reset mid access", {ras_n, cas_n}, 2'b11);
        check(!fvalid, "R1 reset mid access valid", fvalid, 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        run(2000, 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule